// File: doc/BRIEF.md
# Unaligned Operand Bus Cycle Splitter

This block sits between a load/store unit and a 32-bit system bus. It takes one logical access and turns it into one or two aligned bus cycles. The access is a byte, a word or a doubleword, and it may start at any byte address. The block places each operand byte on the data lane its address selects and drives active-low byte enables for exactly those lanes. It then waits for the bus to acknowledge each cycle. For loads it gathers the returned lanes back into a right-justified operand.

When an operand runs past the end of its dword, the access needs two cycles. The cycle for the higher dword, which holds the higher-order bytes, is issued first. The cycle for the base dword follows. Every bus cycle has an address clock marked by a one-clock strobe, then one or more clocks that wait for ready. A single done pulse closes the access. The requester sees a ready flag that is high only while the block is idle.

Top module: `xfer_splitter`

## Requirements
- R1: `req_size` encodes the operand length: 0 is one byte, 1 is two bytes, 2 is four bytes, and 3 is treated as four bytes. The start address `req_addr` may be any byte address.
- R2: On a store, the operand byte j at address A+j is driven on lane (A+j) mod 4, which is `bus_dout[8k+7:8k]` with k = (A+j) mod 4.
- R3: `bus_be_n[k]` is low exactly when lane k carries an operand byte in the current cycle. The low enables are always one contiguous run.
- R4: An operand that lies wholly inside one dword takes exactly one bus cycle, at `bus_addr` = A[31:2].
- R5: An operand that crosses a dword boundary takes two cycles. The first is at A[31:2]+1 (modulo the address width) and carries the high lanes. The second is at A[31:2] and carries the remaining lanes.
- R6: Each bus cycle raises `bus_strobe` for its first clock only. `bus_addr`, `bus_be_n` and `bus_wr` then hold until `bus_rdy` is seen in a later clock, and each clock spent with `bus_rdy` low adds one clock. An access of c cycles with w wait clocks per cycle therefore reaches done c*(2+w)+1 clocks after acceptance.
- R7: On a load, byte j of `rsp_rdata` equals the lane value returned by the cycle that carried address A+j. Bytes at and above the operand length are zero.
- R8: `rsp_done` is high for one clock, the clock after the final cycle's ready. It is issued for loads and stores alike, and it never appears without a preceding ready.
- R9: `req_ready` is high only while no access is in progress. A `req_valid` raised while `req_ready` is low is ignored and produces no bus cycle and no done.
- R10: In reset and after it, the block is idle: `req_ready` is high, all byte enables are high, and `bus_strobe`, `bus_wr` and `rsp_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand length code |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store operand, right-justified |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Load operand, valid with rsp_done |
| bus_addr | output | ADDR_W-2 | Dword address of the current cycle |
| bus_be_n | output | 4 | Active-low lane enables |
| bus_wr | output | 1 | Current cycle is a store |
| bus_strobe | output | 1 | First clock of a bus cycle |
| bus_dout | output | 32 | Store lanes |
| bus_din | input | 32 | Load lanes |
| bus_rdy | input | 1 | Cycle acknowledge |

## Verification
The hardest situation to reach from the ports is a request that arrives while a split access is between its two cycles. The block has to ignore it rather than fold it into the second cycle. The stimulus raises `req_valid` with a different, itself crossing, operand one clock after a split access is accepted. The scoreboard then rejects any bus cycle it did not predict. Crossing accesses are also run at the very top of the address space, so the first cycle's dword address wraps to zero, and with several wait-state counts so the hold rules are exercised.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int LANES = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2, SZ_RSVD = 2'd3} size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WAIT} seq_e;

  function automatic logic [2:0] size_bytes(size_e sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // lanes touched across two adjacent dwords: [3:0] base dword, [7:4] next dword
  function automatic logic [2*LANES-1:0] span_mask(logic [1:0] off, size_e sz);
    logic [2*LANES-1:0] run;
    run = (8'(1) << size_bytes(sz)) - 8'(1);
    return run << off;
  endfunction

  function automatic logic [DATA_W-1:0] lane_bits(logic [LANES-1:0] en);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < LANES; k++) r[8*k +: 8] = {8{en[k]}};
    return r;
  endfunction

  // operand byte j -> lane (j + off) mod 4
  function automatic logic [DATA_W-1:0] rot_up(logic [DATA_W-1:0] d, logic [1:0] off);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < LANES; k++) begin
      logic [1:0] src;
      src = 2'(k) - off;
      r[8*k +: 8] = d[8*src +: 8];
    end
    return r;
  endfunction

  // lane (j + off) mod 4 -> operand byte j
  function automatic logic [DATA_W-1:0] rot_down(logic [DATA_W-1:0] d, logic [1:0] off);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < LANES; k++) begin
      logic [1:0] src;
      src = 2'(k) + off;
      r[8*k +: 8] = d[8*src +: 8];
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] keep_mask(size_e sz);
    logic [LANES:0] t;
    t = (5'd1 << size_bytes(sz)) - 5'd1;
    return lane_bits(t[LANES-1:0]);
  endfunction
endpackage

// File: rtl/lane_planner.sv
module lane_planner
  import xfer_pkg::*;
(
  input  logic [1:0]        off,
  input  size_e             size,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  hi_en,
  output logic [LANES-1:0]  lo_en,
  output logic              split,
  output logic [DATA_W-1:0] lane_wdata
);
  logic [2*LANES-1:0] span;

  assign span       = span_mask(off, size);
  assign lo_en      = span[LANES-1:0];
  assign hi_en      = span[2*LANES-1:LANES];
  assign split      = |hi_en;
  assign lane_wdata = rot_up(wdata, off);
endmodule

// File: rtl/cycle_seq.sv
module cycle_seq
  import xfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic split,
  input  logic rdy,
  output logic active,
  output logic strobe,
  output logic second,
  output logic cyc_wait,
  output logic ack,
  output logic last_ack
);
  seq_e st;
  logic hop;

  assign active   = (st != ST_IDLE);
  assign strobe   = (st == ST_ADDR);
  assign cyc_wait = (st == ST_WAIT);
  assign ack      = cyc_wait && rdy;
  assign hop      = ack && split && !second;
  assign last_ack = ack && !hop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      second <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_ADDR;
          second <= 1'b0;
        end
        ST_ADDR: st <= ST_WAIT;
        ST_WAIT: if (rdy) begin
          if (hop) begin
            st     <= ST_ADDR;
            second <= 1'b1;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/read_merge.sv
module read_merge
  import xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [LANES-1:0]  en,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        off,
  input  size_e             size,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] hold;
  logic [DATA_W-1:0] sel;

  assign sel   = lane_bits(en);
  assign rdata = rot_down(hold, off) & keep_mask(size);

  always_ff @(posedge clk) begin
    if (!rst_n)       hold <= '0;
    else if (clear)   hold <= '0;
    else if (capture) hold <= (hold & ~sel) | (din & sel);
  end
endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              rsp_done,
  output logic [31:0]       rsp_rdata,
  output logic [ADDR_W-3:0] bus_addr,
  output logic [3:0]        bus_be_n,
  output logic              bus_wr,
  output logic              bus_strobe,
  output logic [31:0]       bus_dout,
  input  logic [31:0]       bus_din,
  input  logic              bus_rdy
);
  localparam int DW_W = ADDR_W - 2;

  // request-side plan
  logic [LANES-1:0]  p_hi, p_lo;
  logic              p_split;
  logic [DATA_W-1:0] p_wdata;

  // captured access
  logic [DW_W-1:0]   r_base;
  logic [1:0]        r_off;
  size_e             r_size;
  logic              r_write, r_split;
  logic [LANES-1:0]  r_hi, r_lo;
  logic [DATA_W-1:0] r_wdata;

  // named sequencing events
  logic seq_active, seq_strobe, seq_second, seq_wait, seq_ack, seq_last;
  logic start, first_hi;
  logic [LANES-1:0] cur_en;

  lane_planner u_plan (
    .off(req_addr[1:0]), .size(size_e'(req_size)), .wdata(req_wdata),
    .hi_en(p_hi), .lo_en(p_lo), .split(p_split), .lane_wdata(p_wdata)
  );

  assign start     = req_valid && !seq_active;
  assign req_ready = !seq_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_base  <= '0;
      r_off   <= '0;
      r_size  <= SZ_BYTE;
      r_write <= 1'b0;
      r_split <= 1'b0;
      r_hi    <= '0;
      r_lo    <= '0;
      r_wdata <= '0;
    end else if (start) begin
      r_base  <= req_addr[ADDR_W-1:2];
      r_off   <= req_addr[1:0];
      r_size  <= size_e'(req_size);
      r_write <= req_write;
      r_split <= p_split;
      r_hi    <= p_hi;
      r_lo    <= p_lo;
      r_wdata <= p_wdata;
    end
  end

  cycle_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .split(r_split), .rdy(bus_rdy),
    .active(seq_active), .strobe(seq_strobe), .second(seq_second),
    .cyc_wait(seq_wait), .ack(seq_ack), .last_ack(seq_last)
  );

  // higher dword goes first on a split access
  assign first_hi   = r_split && !seq_second;
  assign cur_en     = first_hi ? r_hi : r_lo;
  assign bus_addr   = first_hi ? r_base + DW_W'(1) : r_base;
  assign bus_be_n   = seq_active ? ~cur_en : '1;
  assign bus_wr     = seq_active && r_write;
  assign bus_strobe = seq_strobe;
  assign bus_dout   = (seq_active && r_write) ? r_wdata : '0;

  read_merge u_merge (
    .clk(clk), .rst_n(rst_n), .clear(start), .capture(seq_ack && !r_write),
    .en(cur_en), .din(bus_din), .off(r_off), .size(r_size), .rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_done <= 1'b0;
    else        rsp_done <= seq_last;
  end
endmodule

// File: rtl/xfer_splitter_chk.sv
module xfer_splitter_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-3:0] bus_addr,
  input logic [3:0]        bus_be_n,
  input logic              bus_wr,
  input logic              bus_strobe,
  input logic              bus_rdy,
  input logic              seq_second,
  input logic              seq_wait
);
  logic [3:0] en_act;
  logic       contig;
  logic [ADDR_W-3:0] prev_addr;

  assign en_act = ~bus_be_n;
  always_comb begin
    contig = (en_act == 4'b0001) || (en_act == 4'b0010) || (en_act == 4'b0100) ||
             (en_act == 4'b1000) || (en_act == 4'b0011) || (en_act == 4'b0110) ||
             (en_act == 4'b1100) || (en_act == 4'b0111) || (en_act == 4'b1110) ||
             (en_act == 4'b1111);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          prev_addr <= '0;
    else if (bus_strobe) prev_addr <= bus_addr;
  end

  // R3
  contig_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_act != 4'b0000) |-> contig);

  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> !bus_strobe);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe || (seq_wait && !bus_rdy)) |=>
      ($stable(bus_addr) && $stable(bus_be_n) && $stable(bus_wr)));

  // R8
  done_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(bus_rdy));

  // R5
  split_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && seq_second) |-> (bus_addr == prev_addr - 1'b1));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_be_n == 4'hF && !bus_strobe && !bus_wr));
endmodule

bind xfer_splitter xfer_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_wr(bus_wr),
  .bus_strobe(bus_strobe), .bus_rdy(bus_rdy),
  .seq_second(seq_second), .seq_wait(seq_wait)
);

// File: tb/xfer_splitter_tb.sv
module xfer_splitter_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, rsp_done;
  logic [31:0] req_addr, req_wdata, rsp_rdata, bus_dout, bus_din;
  logic [1:0]  req_size;
  logic [29:0] bus_addr;
  logic [3:0]  bus_be_n;
  logic        bus_wr, bus_strobe, bus_rdy;

  xfer_splitter u_dut (.*);

  typedef struct packed {logic [29:0] a; logic [3:0] ben; logic wr; logic [31:0] d;} bus_item_t;
  typedef struct packed {logic rd; logic [31:0] data;} rsp_item_t;
  bus_item_t bus_q[$];
  rsp_item_t rsp_q[$];
  int errors = 0, checks = 0, ws_cfg = 0;
  bit finished = 0;

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return a[7:0] ^ {a[3:0], a[11:8]} ^ 8'hA5;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_cycle(logic [29:0] dw, logic [31:0] a, int n, bit wr, logic [31:0] wd);
    bus_item_t it;
    it.a = dw; it.wr = wr; it.d = '0; it.ben = 4'hF;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] rel;
      rel = {dw, 2'(k)} - a;
      if (rel < 32'(n)) begin
        it.ben[k] = 1'b0;
        if (wr) it.d[8*k +: 8] = wd[8*rel[1:0] +: 8];
      end
    end
    bus_q.push_back(it);
  endtask

  task automatic run_op(logic [31:0] a, logic [1:0] sz, bit wr, logic [31:0] wd, int ws, bit poke);
    int n, ncyc, cnt;
    logic [31:0] last;
    rsp_item_t r;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    last = a + 32'(n - 1);
    ncyc = (last[31:2] != a[31:2]) ? 2 : 1;
    if (ncyc == 2) push_cycle(last[31:2], a, n, wr, wd);   // higher dword first
    push_cycle(a[31:2], a, n, wr, wd);
    r.rd = !wr; r.data = '0;
    for (int j = 0; j < n; j++) r.data[8*j +: 8] = mem_byte(a + 32'(j));
    rsp_q.push_back(r);
    ws_cfg = ws;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 1;
    while (!rsp_done && cnt < 1000) begin
      if (poke && cnt == 1) begin
        check(req_ready == 1'b0, "R9 ready low while busy", 64'(req_ready), 64'd0);
        req_valid = 1'b1; req_addr = 32'h1234_5677; req_size = 2'd2; req_write = !wr;
        req_wdata = 32'hDEAD_BEEF;
      end
      if (poke && cnt == 2) req_valid = 1'b0;
      @(negedge clk);
      cnt++;
    end
    req_valid = 1'b0;
    check(cnt == ncyc * (2 + ws) + 1, "R6 accept-to-done clocks", 64'(cnt), 64'(ncyc * (2 + ws) + 1));
  endtask

  // monitor and bus responder
  logic [29:0] cur_a;
  bit pending = 0;
  int wait_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_rdy <= 1'b0; pending = 0;
    end else begin
      bus_rdy <= 1'b0;
      if (bus_strobe) begin
        if (bus_q.size() == 0) begin
          check(0, "R9 unexpected bus cycle", 64'(bus_addr), 64'd0);
        end else begin
          bus_item_t e;
          logic [31:0] lm;
          e = bus_q.pop_front();
          for (int k = 0; k < 4; k++) lm[8*k +: 8] = {8{~e.ben[k]}};
          check(bus_addr == e.a, "R4 R5 cycle dword address", 64'(bus_addr), 64'(e.a));
          check(bus_be_n == e.ben, "R1 R3 byte enables", 64'(bus_be_n), 64'(e.ben));
          check(bus_wr == e.wr, "R6 cycle direction", 64'(bus_wr), 64'(e.wr));
          if (e.wr) check((bus_dout & lm) == e.d, "R2 store lanes", 64'(bus_dout & lm), 64'(e.d));
        end
        cur_a = bus_addr; pending = 1; wait_cnt = ws_cfg;
      end else if (pending) begin
        if (wait_cnt == 0) begin
          bus_rdy <= 1'b1;
          for (int k = 0; k < 4; k++) bus_din[8*k +: 8] <= mem_byte({cur_a, 2'(k)});
          pending = 0;
        end else begin
          wait_cnt--;
        end
      end
      if (rsp_done) begin
        if (rsp_q.size() == 0) begin
          check(0, "R8 unexpected done", 64'd1, 64'd0);
        end else begin
          rsp_item_t e;
          e = rsp_q.pop_front();
          if (e.rd) check(rsp_rdata == e.data, "R7 load operand", 64'(rsp_rdata), 64'(e.data));
          else      check(1'b1, "R8 store done", 64'd1, 64'd1);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_wdata = '0; bus_din = '0;
    repeat (3) @(negedge clk);
    check(bus_be_n == 4'hF, "R10 enables in reset", 64'(bus_be_n), 64'hF);
    check(!bus_strobe && !bus_wr, "R10 strobe/wr in reset", 64'({bus_strobe, bus_wr}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
    check(rsp_done == 1'b0, "R10 done after reset", 64'(rsp_done), 64'd0);
    check(bus_be_n == 4'hF, "R10 enables after reset", 64'(bus_be_n), 64'hF);

    for (int wr = 0; wr < 2; wr++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++)
          run_op(32'h0000_1000 + 32'(sz * 64) + 32'(off), 2'(sz), bit'(wr),
                 32'hC0DE_7301 ^ 32'(sz * 16 + off * 4 + wr), (off + sz) % 3, (off == 3));
    run_op(32'h0000_2002, 2'd3, 1'b0, 32'h0, 1, 1'b0);            // R1 reserved code as dword
    run_op(32'h0000_2003, 2'd3, 1'b1, 32'hA1B2_C3D4, 0, 1'b0);
    run_op(32'hFFFF_FFFE, 2'd2, 1'b0, 32'h0, 2, 1'b1);            // R5 address wrap
    run_op(32'hFFFF_FFFF, 2'd1, 1'b1, 32'h0000_5AA5, 0, 1'b0);
    run_op(32'h0000_3001, 2'd1, 1'b0, 32'h0, 4, 1'b1);

    repeat (10) @(negedge clk);
    check(bus_q.size() == 0, "R9 leftover bus cycles", 64'(bus_q.size()), 64'd0);
    check(rsp_q.size() == 0, "R8 missing done", 64'(rsp_q.size()), 64'd0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule